// File: doc/BRIEF.md
# Ethernet PHY Control Register with Deferred Negotiation Commit

This block holds the 16-bit control word of an Ethernet PHY and turns it into the link-control signals that the rest of the PHY uses. Software writes the whole word in one cycle through a plain write port and reads it back on a combinational read bus. Most fields take effect as soon as they are written. The auto-negotiation enable is the exception. Its written value sits in a shadow and reaches the active state only at a commit event. A commit event is a software reset, a negotiation restart, or the port leaving power-down.

Downstream logic gets the following from the block:
- a one-cycle commit strobe;
- a one-cycle PHY reset pulse;
- a one-cycle restart-negotiation pulse;
- the effective negotiation state and the gigabit duplex to advertise;
- the forced speed and duplex;
- loopback and power-down levels.

When the speed field forces gigabit, negotiation stays on even if the active enable is cleared. In that case exactly one gigabit duplex mode is advertised, and the duplex bit of this register selects it.

Top module: `phyctl_reg`

## Requirements
- R1: After hardware reset the word reads 0x1100 (negotiation enable bit 12 = 1, duplex bit 8 = 1, all else 0). `aneg_on` and both gigabit advertise outputs are 1, `speed_sel` is 0, and no strobe or pulse is high.
- R2: A write to bit 12 changes the read value at once. It does not change the active enable, and so does not change `aneg_on`, until a commit event.
- R3: Writing bit 15 = 1 makes bit 15 read 1 for exactly one cycle after the write edge. On the next edge `phy_rst_pulse` and `commit_strobe` go high for one cycle, bit 15 reads 0, and the active enable takes the shadow value.
- R4: Writing bit 9 = 1 makes bit 9 read 1 for one cycle. On the next edge `restart_pulse` and `commit_strobe` go high for one cycle, bit 9 reads 0, the active enable takes the shadow value, and `phy_rst_pulse` stays low.
- R5: A write that clears bit 11 while it is set (power-down exit) sets both bit 15 and bit 9 for one cycle. One edge later `phy_rst_pulse`, `restart_pulse` and `commit_strobe` all go high. Entering power-down raises none of them. `power_down` follows bit 11.
- R6: Forced speed is coded {bit 6, bit 13}. The code 00 gives `speed_sel` = 0 (10 Mbps), 01 gives 1 (100 Mbps), and 10 and the reserved code 11 both give 2 (1000 Mbps).
- R7: With the active enable at 0 and bit 6 = 1 (gigabit forced), `aneg_on` stays 1. `adv_gig_full` equals bit 8 and `adv_gig_half` equals its inverse.
- R8: With the active enable at 1, `aneg_on` and both advertise outputs are 1. With the active enable at 0 and gigabit not forced, all three are 0.
- R9: `loopback_on` follows bit 14 and `duplex_full` follows bit 8, both from the write edge.
- R10: Bits 0–5, 7 and 10 always read 0. Writing them has no effect on any output.
- R11: Every strobe and pulse lasts exactly one cycle. A request bit that already reads 1 absorbs a repeat request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the whole control word |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Current register view (shadow enable, request bits, plain fields) |
| aneg_on | output | 1 | Effective auto-negotiation enable |
| adv_gig_full | output | 1 | Advertise gigabit full duplex |
| adv_gig_half | output | 1 | Advertise gigabit half duplex |
| speed_sel | output | 2 | Forced speed: 0 = 10, 1 = 100, 2 = 1000 Mbps |
| duplex_full | output | 1 | Forced duplex, 1 = full |
| loopback_on | output | 1 | Loopback enable |
| power_down | output | 1 | Power-down level |
| commit_strobe | output | 1 | One-cycle strobe when the shadow enable is committed |
| phy_rst_pulse | output | 1 | One-cycle PHY software reset pulse |
| restart_pulse | output | 1 | One-cycle negotiation restart pulse |

## Verification
The assertions check several rules on every cycle:
- the active enable never moves without a commit strobe;
- request bits never stay set for two cycles, and the pulses never last two cycles;
- a power-down exit always arms both requests;
- a forced gigabit speed always keeps negotiation on, with exactly one duplex advertised.

Only the bench scenarios can show three other things: the exact cycle at which each request bit reads back, that the committed enable takes the shadowed value rather than the live write, and that the reserved bits and the speed codes read and decode as specified.

// File: rtl/phyctl_pkg.sv
// Package: shared bit positions, field record and speed codes for the
// PHY control register. Assumes a 16-bit control word.
package phyctl_pkg;

    localparam int CTRL_W      = 16;
    localparam int SPD_W       = 2;

    // Bit positions that neighbouring logic decodes.
    localparam int POS_RESET   = 15;
    localparam int POS_LOOP    = 14;
    localparam int POS_SPD_LO  = 13;
    localparam int POS_ANE     = 12;
    localparam int POS_PDOWN   = 11;
    localparam int POS_RESTART = 9;
    localparam int POS_DUPLEX  = 8;
    localparam int POS_SPD_HI  = 6;

    // Forced speed codes presented on speed_sel.
    typedef enum logic [SPD_W-1:0] {
        SPEED_10   = 2'b00,
        SPEED_100  = 2'b01,
        SPEED_1000 = 2'b10
    } speed_e;

    // Fields that take effect immediately on a write.
    typedef struct packed {
        logic loop;
        logic spd_hi;
        logic spd_lo;
        logic pdown;
        logic duplex;
    } live_fields_t;

endpackage

// File: rtl/phyctl_fields.sv
// Module: phyctl_fields
// Holds the control fields that take effect on the write edge (loopback,
// speed, power-down, duplex) and flags a power-down exit, which is a write
// that clears power-down while it is set.
// Assumes: wr_en is one write per cycle and the whole word is written.
module phyctl_fields
    import phyctl_pkg::*;
#(
    parameter logic RST_DUPLEX = 1'b1,
    parameter logic RST_LOOP   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_loop,
    input  logic         wr_spd_hi,
    input  logic         wr_spd_lo,
    input  logic         wr_pdown,
    input  logic         wr_duplex,
    output live_fields_t fields,
    output logic         pd_exit
);

    localparam live_fields_t FIELD_DEFAULT = '{
        loop:   RST_LOOP,
        spd_hi: 1'b0,
        spd_lo: 1'b0,
        pdown:  1'b0,
        duplex: RST_DUPLEX
    };

    live_fields_t fields_q;
    live_fields_t fields_d;

    // Gather the written values into the field record.
    always_comb begin
        fields_d        = fields_q;
        fields_d.loop   = wr_loop;
        fields_d.spd_hi = wr_spd_hi;
        fields_d.spd_lo = wr_spd_lo;
        fields_d.pdown  = wr_pdown;
        fields_d.duplex = wr_duplex;
    end

    // Store the immediate fields; a hardware reset restores the defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= FIELD_DEFAULT;
        end else if (wr_en) begin
            fields_q <= fields_d;
        end
    end

    // A write that clears a set power-down bit is a power-down exit.
    always_comb begin
        pd_exit = wr_en && fields_q.pdown && !wr_pdown;
    end

    assign fields = fields_q;

endmodule

// File: rtl/phyctl_commit.sv
// Module: phyctl_commit
// Keeps the auto-negotiation enable as a shadow and an active copy. It
// tracks the self-clearing reset and restart request bits. At each commit
// event it copies the shadow into the active copy and raises one-cycle
// strobes.
// Assumes: a request bit that is already set absorbs a repeat request, so
// every request lasts exactly one cycle.
module phyctl_commit
    import phyctl_pkg::*;
#(
    parameter logic RST_ANE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_ane,
    input  logic wr_reset,
    input  logic wr_restart,
    input  logic pd_exit,
    output logic ane_shadow,
    output logic ane_active,
    output logic reset_req,
    output logic restart_req,
    output logic commit_strobe,
    output logic phy_rst_pulse,
    output logic restart_pulse
);

    logic commit_now;
    logic reset_set;
    logic restart_set;

    // Sources that arm each request bit.
    always_comb begin
        reset_set   = (wr_en && wr_reset) || pd_exit;
        restart_set = (wr_en && wr_restart) || pd_exit;
        commit_now  = reset_req || restart_req;
    end

    // Shadow enable: follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ane_shadow <= RST_ANE;
        end else if (wr_en) begin
            ane_shadow <= wr_ane;
        end
    end

    // Software reset request: set for one cycle, then clears itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
        end else if (reset_req) begin
            reset_req <= 1'b0;
        end else begin
            reset_req <= reset_set;
        end
    end

    // Restart request: set for one cycle, then clears itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_req <= 1'b0;
        end else if (restart_req) begin
            restart_req <= 1'b0;
        end else begin
            restart_req <= restart_set;
        end
    end

    // Active enable: loads the shadow at a commit event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ane_active <= RST_ANE;
        end else if (commit_now) begin
            ane_active <= ane_shadow;
        end
    end

    // One-cycle strobes toward downstream logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_strobe <= 1'b0;
            phy_rst_pulse <= 1'b0;
            restart_pulse <= 1'b0;
        end else begin
            commit_strobe <= commit_now;
            phy_rst_pulse <= reset_req;
            restart_pulse <= restart_req;
        end
    end

    AST_ANE_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ane_active != $past(ane_active)) |-> commit_strobe); // R2
    AST_RESET_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R3
    AST_RESTART_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req); // R4
    AST_PD_EXIT_ARMS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_exit && !reset_req) |=> reset_req); // R5
    AST_PD_EXIT_ARMS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_exit && !restart_req) |=> restart_req); // R5
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst_pulse |=> !phy_rst_pulse); // R11

endmodule

// File: rtl/phyctl_decode.sv
// Module: phyctl_decode
// Derives the effective link controls from the active enable and the
// immediate fields. A forced gigabit speed keeps negotiation on and
// advertises only the duplex that the duplex field selects.
// Assumes: purely combinational; the inputs come straight from registers.
module phyctl_decode
    import phyctl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ane_active,
    input  live_fields_t fields,
    output logic         aneg_on,
    output logic         adv_gig_full,
    output logic         adv_gig_half,
    output logic [SPD_W-1:0] speed_sel
);

    logic   gig_forced;
    speed_e speed_code;

    // Map the two speed bits; the reserved code folds onto gigabit.
    always_comb begin
        gig_forced = fields.spd_hi;
        if (fields.spd_hi) begin
            speed_code = SPEED_1000;
        end else if (fields.spd_lo) begin
            speed_code = SPEED_100;
        end else begin
            speed_code = SPEED_10;
        end
        speed_sel = speed_code;
    end

    // Negotiation state and gigabit advertisement.
    always_comb begin
        if (ane_active) begin
            aneg_on      = 1'b1;
            adv_gig_full = 1'b1;
            adv_gig_half = 1'b1;
        end else if (gig_forced) begin
            aneg_on      = 1'b1;
            adv_gig_full = fields.duplex;
            adv_gig_half = !fields.duplex;
        end else begin
            aneg_on      = 1'b0;
            adv_gig_full = 1'b0;
            adv_gig_half = 1'b0;
        end
    end

    AST_GIG_KEEPS_ANEG: assert property (@(posedge clk) disable iff (!rst_n)
        fields.spd_hi |-> aneg_on); // R7
    AST_GIG_ONE_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        (!ane_active && fields.spd_hi) |-> $countones({adv_gig_full, adv_gig_half}) == 1); // R7
    AST_ANEG_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ane_active && !fields.spd_hi) |-> (!aneg_on && !adv_gig_full && !adv_gig_half)); // R8

endmodule

// File: rtl/phyctl_reg.sv
// Module: phyctl_reg
// Top of the PHY control register. It splits the written word into the
// immediate fields and the shadowed negotiation enable, builds the read
// view, and drives the effective link-control outputs.
// Assumes: synchronous active-low reset; reads are combinational.
module phyctl_reg
    import phyctl_pkg::*;
#(
    parameter logic RST_ANE    = 1'b1,
    parameter logic RST_DUPLEX = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              aneg_on,
    output logic              adv_gig_full,
    output logic              adv_gig_half,
    output logic [SPD_W-1:0]  speed_sel,
    output logic              duplex_full,
    output logic              loopback_on,
    output logic              power_down,
    output logic              commit_strobe,
    output logic              phy_rst_pulse,
    output logic              restart_pulse
);

    live_fields_t fields;
    logic         pd_exit;
    logic         ane_shadow;
    logic         ane_active;
    logic         reset_req;
    logic         restart_req;
    logic         unused_wr_bits;

    // Bits with no function; kept visible so they are not silently lost.
    assign unused_wr_bits = ^{wr_data[10], wr_data[7], wr_data[5:0]};

    phyctl_fields #(
        .RST_DUPLEX (RST_DUPLEX),
        .RST_LOOP   (1'b0)
    ) u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_loop   (wr_data[POS_LOOP]),
        .wr_spd_hi (wr_data[POS_SPD_HI]),
        .wr_spd_lo (wr_data[POS_SPD_LO]),
        .wr_pdown  (wr_data[POS_PDOWN]),
        .wr_duplex (wr_data[POS_DUPLEX]),
        .fields    (fields),
        .pd_exit   (pd_exit)
    );

    phyctl_commit #(
        .RST_ANE (RST_ANE)
    ) u_commit (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_ane        (wr_data[POS_ANE]),
        .wr_reset      (wr_data[POS_RESET]),
        .wr_restart    (wr_data[POS_RESTART]),
        .pd_exit       (pd_exit),
        .ane_shadow    (ane_shadow),
        .ane_active    (ane_active),
        .reset_req     (reset_req),
        .restart_req   (restart_req),
        .commit_strobe (commit_strobe),
        .phy_rst_pulse (phy_rst_pulse),
        .restart_pulse (restart_pulse)
    );

    phyctl_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .ane_active   (ane_active),
        .fields       (fields),
        .aneg_on      (aneg_on),
        .adv_gig_full (adv_gig_full),
        .adv_gig_half (adv_gig_half),
        .speed_sel    (speed_sel)
    );

    // Assemble the read view; unassigned bit positions read zero.
    always_comb begin
        rd_data              = '0;
        rd_data[POS_RESET]   = reset_req;
        rd_data[POS_LOOP]    = fields.loop;
        rd_data[POS_SPD_LO]  = fields.spd_lo;
        rd_data[POS_ANE]     = ane_shadow;
        rd_data[POS_PDOWN]   = fields.pdown;
        rd_data[POS_RESTART] = restart_req;
        rd_data[POS_DUPLEX]  = fields.duplex;
        rd_data[POS_SPD_HI]  = fields.spd_hi;
    end

    // Level outputs taken straight from the immediate fields.
    always_comb begin
        duplex_full = fields.duplex;
        loopback_on = fields.loop;
        power_down  = fields.pdown;
    end

    AST_RESTART_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse); // R11
    AST_PULSE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rst_pulse || restart_pulse) |-> commit_strobe); // R3

endmodule

// File: tb/phyctl_reg_tb.sv
// Directed bench for phyctl_reg: one task per scenario, each checking itself.
module phyctl_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        aneg_on, adv_gig_full, adv_gig_half;
    logic [1:0]  speed_sel;
    logic        duplex_full, loopback_on, power_down;
    logic        commit_strobe, phy_rst_pulse, restart_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    phyctl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .aneg_on(aneg_on), .adv_gig_full(adv_gig_full),
        .adv_gig_half(adv_gig_half), .speed_sel(speed_sel),
        .duplex_full(duplex_full), .loopback_on(loopback_on),
        .power_down(power_down), .commit_strobe(commit_strobe),
        .phy_rst_pulse(phy_rst_pulse), .restart_pulse(restart_pulse)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    // {phy_rst_pulse, restart_pulse, commit_strobe}
    function automatic logic [15:0] strobes();
        return {13'd0, phy_rst_pulse, restart_pulse, commit_strobe};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    // Drive one write; returns at the negedge after the write edge.
    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rd_data", rd_data, 16'h1100);
        chk("R1", "aneg/adv", {13'd0, aneg_on, adv_gig_full, adv_gig_half}, 16'h7);
        chk("R1", "speed_sel", {14'd0, speed_sel}, 16'h0);
        chk("R1", "strobes", strobes(), 16'h0);
    endtask

    task automatic t_shadow();
        wr(16'h0100);
        chk("R2", "rd_data after write", rd_data, 16'h0100);
        chk("R2", "aneg_on held", {15'd0, aneg_on}, 16'h1);
        step(); step();
        chk("R2", "aneg_on still held", {15'd0, aneg_on}, 16'h1);
        chk("R2", "no commit", strobes(), 16'h0);
    endtask

    task automatic t_soft_reset();
        wr(16'h8100);
        chk("R3", "bit15 set", rd_data, 16'h8100);
        chk("R3", "no pulse yet", strobes(), 16'h0);
        step();
        chk("R3", "reset+commit", strobes(), 16'h5);
        chk("R3", "bit15 cleared", rd_data, 16'h0100);
        chk("R3", "enable committed", {15'd0, aneg_on}, 16'h0);
        step();
        chk("R11", "pulses one cycle", strobes(), 16'h0);
        chk("R8", "off, nothing advertised",
            {13'd0, aneg_on, adv_gig_full, adv_gig_half}, 16'h0);
    endtask

    task automatic t_forced_gig();
        wr(16'h0140);
        chk("R7", "gig full: aneg/full/half",
            {13'd0, aneg_on, adv_gig_full, adv_gig_half}, 16'h6);
        chk("R6", "code 10", {14'd0, speed_sel}, 16'h2);
        wr(16'h0040);
        chk("R7", "gig half: aneg/full/half",
            {13'd0, aneg_on, adv_gig_full, adv_gig_half}, 16'h5);
        wr(16'h2040);
        chk("R6", "code 11 as gig", {14'd0, speed_sel}, 16'h2);
        chk("R7", "aneg kept on", {15'd0, aneg_on}, 16'h1);
    endtask

    task automatic t_speed();
        wr(16'h0000);
        chk("R6", "code 00", {14'd0, speed_sel}, 16'h0);
        chk("R8", "aneg off", {15'd0, aneg_on}, 16'h0);
        wr(16'h2000);
        chk("R6", "code 01", {14'd0, speed_sel}, 16'h1);
    endtask

    task automatic t_restart();
        wr(16'h1200);
        chk("R4", "bit9 set", rd_data, 16'h1200);
        chk("R4", "enable not yet", {15'd0, aneg_on}, 16'h0);
        step();
        chk("R4", "restart+commit only", strobes(), 16'h3);
        chk("R4", "bit9 cleared", rd_data, 16'h1000);
        chk("R8", "enable committed, both advertised",
            {13'd0, aneg_on, adv_gig_full, adv_gig_half}, 16'h7);
        step();
        chk("R11", "restart one cycle", strobes(), 16'h0);
    endtask

    task automatic t_power();
        wr(16'h0800);
        chk("R5", "enter read", rd_data, 16'h0800);
        chk("R5", "power_down", {15'd0, power_down}, 16'h1);
        step();
        chk("R5", "no pulse on entry", strobes(), 16'h0);
        chk("R5", "enable unchanged", {15'd0, aneg_on}, 16'h1);
        wr(16'h0000);
        chk("R5", "exit arms both", rd_data, 16'h8200);
        step();
        chk("R5", "exit pulses", strobes(), 16'h7);
        chk("R5", "enable committed", {15'd0, aneg_on}, 16'h0);
        chk("R5", "requests cleared", rd_data, 16'h0000);
    endtask

    task automatic t_levels();
        wr(16'h4100);
        chk("R9", "loop/duplex", {14'd0, loopback_on, duplex_full}, 16'h3);
        chk("R9", "rd_data", rd_data, 16'h4100);
    endtask

    task automatic t_reserved();
        wr(16'h04BF);
        chk("R10", "reserved read zero", rd_data, 16'h0000);
        chk("R10", "levels", {12'd0, loopback_on, duplex_full, power_down, aneg_on}, 16'h0);
        chk("R10", "speed", {14'd0, speed_sel}, 16'h0);
        step();
        chk("R10", "no strobes", strobes(), 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_shadow();
        t_soft_reset();
        t_forced_gig();
        t_speed();
        t_restart();
        t_power();
        t_levels();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule